// File: doc/BRIEF.md
# Flow-Gated Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. A one-cycle enable at sixteen times the bit rate paces it, so every serial bit lasts sixteen enable ticks. The transmitter takes characters from an external holding queue through a valid/take pair. Each character goes out as a low start bit, then the data bits least-significant first, then an optional parity bit, then one, one-and-a-half or two high stop bits. The line rests high between characters. The framing inputs are latched when a character is loaded, so a change to them affects only the next character.

With automatic clear-to-send gating enabled, the transmitter reads the clear-to-send input before each new character. When the line is idle, a queued character starts only on a tick where the input is active. During a frame, the decision for the next character is taken once, at tick 8 of the final stop bit. If the input is inactive at that tick, the next character waits. If the input drops after that tick, the next character follows back to back. A character that has started always completes.

A break control forces the line low for as long as it is held. The state machine keeps running underneath while break is held.

The state machine has five states:

- `ST_IDLE`: the line is high.
- `ST_START`: the start bit.
- `ST_DATA`: the data bits.
- `ST_PARITY`: the parity bit.
- `ST_STOP`: the stop period.

Its transitions are:

- idle→start: a tick with a queued character and clearance.
- start→data: the end of the start bit.
- data→data: a data bit ends and more data bits remain.
- data→parity: the last data bit ends and parity is enabled.
- data→stop: the last data bit ends and parity is off.
- parity→stop: the end of the parity bit.
- stop→start: the stop period ends, the midpoint decision allowed the next character and one is queued.
- stop→idle: the stop period ends and no next character starts.

Top module: `cts_gated_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is off, `txd` is 1, `busy` is 0, and `tx_empty` equals the inverse of `q_valid`.
- R2: A frame starts with one start bit at 0. The data bits follow least-significant bit first. Every start, data and parity bit lasts exactly 16 `tick_16x` pulses, and `txd` changes only on cycles that carry a tick, unless `brk` changes.
- R3: `len_sel` selects the number of data bits: 00=5, 01=6, 10=7, 11=8. Bits of `q_data` above that length are not sent.
- R4: With `par_en`=1, one parity bit follows the data bits. `par_odd`=0 makes the total count of ones in data and parity even, and `par_odd`=1 makes it odd. With `par_en`=0, no parity bit is sent.
- R5: With `stop_two`=0, the stop period is 16 ticks at 1. With `stop_two`=1, the stop period is 24 ticks for 5-bit characters and 32 ticks for 6-, 7- or 8-bit characters.
- R6: When the next character is allowed and already queued, its start bit begins on the tick that ends the previous stop period. Two consecutive start edges are then exactly one frame length apart.
- R7: With `auto_cts_en`=0, `cts` has no effect: queued characters are sent back to back.
- R8: With `auto_cts_en`=1 and the line idle, a queued character starts only on a tick where `cts`=1. While `cts`=0, `txd` stays 1, `busy` stays 0 and the character stays queued.
- R9: With `auto_cts_en`=1, `cts` is sampled at tick 8 of the final stop bit, which is tick 8, 16 or 24 of the stop period. If it is 0 there, the next character does not start at the end of the frame. If it drops after that tick, the next character still starts back to back.
- R10: While `brk`=1, `txd` is 0.
- R11: A frame in progress always completes, whatever `cts` does.
- R12: `q_take` pulses for exactly one cycle per character, only while `q_valid`=1, and `busy` is 1 from the next cycle until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | One-cycle enable at 16 times the bit rate |
| q_data | input | 8 | Character at the head of the holding queue |
| q_valid | input | 1 | Holding queue is not empty |
| q_take | output | 1 | Pops the queue head; the character is loaded in this cycle |
| len_sel | input | 2 | Data length select (00=5 to 11=8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_two | input | 1 | 0 = one stop bit; 1 = two stop bits (1.5 with 5-bit characters) |
| auto_cts_en | input | 1 | Enables clear-to-send gating |
| cts | input | 1 | Clear to send, active high |
| brk | input | 1 | Forces the line low while set |
| txd | output | 1 | Serial output |
| busy | output | 1 | A frame is in progress |
| tx_empty | output | 1 | No frame in progress and queue empty |

## Verification
Two functions can fall into the same cycle here. One is the end of a stop period, which loads the next queued character. The other is the clear-to-send decision that governs that load, which is latched eight ticks earlier. The bench queues two characters with gating on. It then drops `cts` either well before the final stop-bit midpoint or a few cycles after it. In the first case the line must stay idle past the frame end, with the character still queued. In the second case the next start edge must follow the previous one by exactly one frame length. The same spacing check is applied to the 1.5- and 2-stop settings, where the stop end and the load coincide at 24 and 32 ticks.

// File: rtl/ctsx_pkg.sv
package ctsx_pkg;

    localparam int BIT_TICKS  = 16;
    localparam int HALF_TICKS = BIT_TICKS / 2;
    localparam int CNT_W      = $clog2(2 * BIT_TICKS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic [3:0]       nbits;
        logic             par_en;
        logic             par_odd;
        logic [CNT_W-1:0] stop_ticks;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_frame(
        input logic [1:0] len_sel,
        input logic       par_en,
        input logic       par_odd,
        input logic       stop_two
    );
        frame_cfg_t c;
        c.nbits   = 4'd5 + {2'b00, len_sel};
        c.par_en  = par_en;
        c.par_odd = par_odd;
        if (!stop_two)
            c.stop_ticks = CNT_W'(BIT_TICKS);
        else if (len_sel == 2'b00)
            c.stop_ticks = CNT_W'(BIT_TICKS + HALF_TICKS);
        else
            c.stop_ticks = CNT_W'(2 * BIT_TICKS);
        return c;
    endfunction

endpackage

// File: rtl/ctsx_tick_counter.sv
module ctsx_tick_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= clr ? '0 : count + W'(1);
    end

endmodule

// File: rtl/ctsx_shifter.sv
module ctsx_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] din,
    input  logic [3:0]    nbits,
    input  logic          par_odd,
    output logic          lsb,
    output logic          par_bit
);

    logic [DW-1:0] sh_q;
    logic          par_q;
    logic          par_calc;

    // parity over the active data bits only
    always_comb begin
        par_calc = par_odd;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(nbits))
                par_calc = par_calc ^ din[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= din;
            par_q <= par_calc;
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[DW-1:1]};
        end
    end

    assign lsb     = sh_q[0];
    assign par_bit = par_q;

endmodule

// File: rtl/ctsx_cts_gate.sv
module ctsx_cts_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic auto_en,
    input  logic cts,
    output logic permit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            permit <= 1'b0;
        else if (sample)
            permit <= !auto_en || cts;
    end

endmodule

// File: rtl/cts_gated_uart_tx.sv
module cts_gated_uart_tx
    import ctsx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic [DATA_W-1:0] q_data,
    input  logic              q_valid,
    output logic              q_take,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_two,
    input  logic              auto_cts_en,
    input  logic              cts,
    input  logic              brk,
    output logic              txd,
    output logic              busy,
    output logic              tx_empty
);

    tx_state_t        state_q, state_d;
    frame_cfg_t       cfg_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [3:0]       bit_idx_q;
    logic             clr_cnt, load, shift, sample;
    logic             bit_end, stop_mid, stop_end, last_data;
    logic             permit, lsb, par_bit;
    logic             line_bit;

    ctsx_tick_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_16x),
        .clr   (clr_cnt),
        .count (cnt)
    );

    ctsx_shifter #(.DW(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .din     (q_data),
        .nbits   (decode_frame(len_sel, par_en, par_odd, stop_two).nbits),
        .par_odd (par_odd),
        .lsb     (lsb),
        .par_bit (par_bit)
    );

    ctsx_cts_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .auto_en (auto_cts_en),
        .cts     (cts),
        .permit  (permit)
    );

    assign cnt_nx    = cnt + CNT_W'(1);
    assign bit_end   = tick_16x && (cnt == CNT_W'(BIT_TICKS - 1));
    assign stop_mid  = tick_16x && (cnt_nx == cfg_q.stop_ticks - CNT_W'(HALF_TICKS));
    assign stop_end  = tick_16x && (cnt_nx == cfg_q.stop_ticks);
    assign last_data = (bit_idx_q == cfg_q.nbits - 4'd1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        clr_cnt = 1'b0;
        load    = 1'b0;
        shift   = 1'b0;
        sample  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clr_cnt = 1'b1;
                if (tick_16x && q_valid && (!auto_cts_en || cts)) begin
                    load    = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    clr_cnt = 1'b1;
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    clr_cnt = 1'b1;
                    if (last_data)
                        state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
                    else
                        shift = 1'b1;
                end
            end
            ST_PARITY: begin
                if (bit_end) begin
                    clr_cnt = 1'b1;
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                sample = stop_mid;
                if (stop_end) begin
                    clr_cnt = 1'b1;
                    if (permit && q_valid) begin
                        load    = 1'b1;
                        state_d = ST_START;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and per-character context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            bit_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cfg_q     <= decode_frame(len_sel, par_en, par_odd, stop_two);
                bit_idx_q <= '0;
            end else if (shift) begin
                bit_idx_q <= bit_idx_q + 4'd1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   line_bit = 1'b1;
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = lsb;
            ST_PARITY: line_bit = par_bit;
            ST_STOP:   line_bit = 1'b1;
            default:   line_bit = 1'b1;
        endcase
        txd      = brk ? 1'b0 : line_bit;
        busy     = (state_q != ST_IDLE);
        tx_empty = (state_q == ST_IDLE) && !q_valid;
        q_take   = load;
    end

endmodule

// File: rtl/ctsx_tx_chk.sv
module ctsx_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_16x,
    input logic q_valid,
    input logic q_take,
    input logic auto_cts_en,
    input logic cts,
    input logic brk,
    input logic txd,
    input logic busy
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk) |-> txd);

    // R12
    take_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_take |-> q_valid);

    // R12
    take_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_take |=> busy);

    // R2
    frame_opens_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !brk) |-> !txd);

    // R2
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_16x && !brk) |=> (brk || $stable(txd)));

    // R8
    idle_start_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && q_take) |-> (!auto_cts_en || cts));

endmodule

bind cts_gated_uart_tx ctsx_tx_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_16x    (tick_16x),
    .q_valid     (q_valid),
    .q_take      (q_take),
    .auto_cts_en (auto_cts_en),
    .cts         (cts),
    .brk         (brk),
    .txd         (txd),
    .busy        (busy)
);

// File: tb/cts_gated_uart_tx_tb_top.sv
module cts_gated_uart_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CYC    = 16 * TICK_DIV;

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         pe;
        bit         po;
        bit         st2;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b0;
    logic [7:0] q_data = 8'h00;
    logic       q_valid = 1'b0;
    logic       q_take;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop_two = 1'b0;
    logic       auto_cts_en = 1'b0;
    logic       cts = 1'b1;
    logic       brk = 1'b0;
    logic       txd, busy, tx_empty;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   ph = 0;
    bit   took = 1'b0;
    bit   mon_en = 1'b1;
    bit   prev_txd = 1'b1;
    int   frames_seen = 0;
    logic [7:0] txq[$];
    exp_t       exp_q[$];
    int         start_log[$];
    event       start_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    cts_gated_uart_tx dut_i (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x),
        .q_data(q_data), .q_valid(q_valid), .q_take(q_take),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .stop_two(stop_two), .auto_cts_en(auto_cts_en), .cts(cts),
        .brk(brk), .txd(txd), .busy(busy), .tx_empty(tx_empty)
    );

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        took <= q_take;
    end

    // tick generation and holding-queue model
    always @(negedge clk) begin
        if (rst_n) begin
            ph = (ph + 1) % TICK_DIV;
            tick_16x = (ph == 0);
        end
        if (took && txq.size() > 0) void'(txq.pop_front());
        q_valid = (txq.size() > 0);
        q_data  = (txq.size() > 0) ? txq[0] : 8'h00;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_char(input logic [7:0] d);
        exp_t e;
        e.d   = d;
        e.nb  = 5 + int'(len_sel);
        e.pe  = par_en;
        e.po  = par_odd;
        e.st2 = stop_two;
        exp_q.push_back(e);
        txq.push_back(d);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || txq.size() != 0);
        repeat (40) @(negedge clk);
    endtask

    function automatic int frame_cyc(input int nb, input bit pe, input bit st2);
        int st;
        st = !st2 ? 16 : (nb == 5 ? 24 : 32);
        return (16 * (1 + nb + (pe ? 1 : 0)) + st) * TICK_DIV;
    endfunction

    // monitor: decodes frames and compares against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mon_en && prev_txd && !txd) begin
                exp_t e;
                logic [7:0] got;
                int ones;
                bit pbit;
                start_log.push_back(cyc);
                ->start_ev;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected frame", 1, 0);
                    e.d = 0; e.nb = 8; e.pe = 0; e.po = 0; e.st2 = 0;
                end else begin
                    e = exp_q.pop_front();
                end
                repeat (BIT_CYC/2) @(negedge clk);
                check(txd == 1'b0, "R2 start bit low", int'(txd), 0);
                got = 8'h00;
                ones = 0;
                for (int i = 0; i < e.nb; i++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    got[i] = txd;
                    if (txd) ones++;
                end
                check(got == (e.d & 8'((1 << e.nb) - 1)), "R3 data bits LSB first",
                      int'(got), int'(e.d & 8'((1 << e.nb) - 1)));
                if (e.pe) begin
                    repeat (BIT_CYC) @(negedge clk);
                    pbit = txd;
                    if (pbit) ones++;
                    check((ones % 2) == (e.po ? 1 : 0), "R4 parity bit", ones % 2, e.po ? 1 : 0);
                end
                repeat (BIT_CYC) @(negedge clk);
                check(txd == 1'b1, "R5 stop bit high", int'(txd), 1);
                frames_seen++;
            end
            prev_txd = txd;
        end
    end

    function automatic int last_gap();
        return start_log[start_log.size()-1] - start_log[start_log.size()-2];
    endfunction

    initial begin
        int n0;
        repeat (10) @(negedge clk);
        check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(tx_empty == 1'b1, "R1 reset tx_empty", int'(tx_empty), 1);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);

        // 8 data bits, no parity, one stop, back to back
        len_sel = 2'b11; par_en = 0; stop_two = 0;
        push_char(8'hA5); push_char(8'h3C);
        repeat (100) @(negedge clk);
        check(busy == 1'b1, "R12 busy during frame", int'(busy), 1);
        wait_idle();
        check(last_gap() == frame_cyc(8, 0, 0), "R6 back-to-back spacing 8N1",
              last_gap(), frame_cyc(8, 0, 0));
        check(tx_empty == 1'b1, "R1 tx_empty after drain", int'(tx_empty), 1);

        // 5 bits, even parity
        len_sel = 2'b00; par_en = 1; par_odd = 0;
        push_char(8'hF5); push_char(8'h0A);
        wait_idle();

        // 7 bits, odd parity, two stop bits
        len_sel = 2'b10; par_odd = 1; stop_two = 1;
        push_char(8'h7F); push_char(8'h01);
        wait_idle();
        check(last_gap() == frame_cyc(7, 1, 1), "R5 two stop bits spacing",
              last_gap(), frame_cyc(7, 1, 1));

        // 5 bits, stop_two -> 1.5 stop
        len_sel = 2'b00; par_en = 0;
        push_char(8'h13); push_char(8'h0C);
        wait_idle();
        check(last_gap() == frame_cyc(5, 0, 1), "R5 one-and-a-half stop spacing",
              last_gap(), frame_cyc(5, 0, 1));

        // 6 bits, stop_two -> 2 stop
        len_sel = 2'b01;
        push_char(8'h2D); push_char(8'h12);
        wait_idle();
        check(last_gap() == frame_cyc(6, 0, 1), "R5 two stop for 6-bit spacing",
              last_gap(), frame_cyc(6, 0, 1));

        // gating off: cts ignored
        len_sel = 2'b11; stop_two = 0; auto_cts_en = 0; cts = 0;
        n0 = frames_seen;
        push_char(8'h5A); push_char(8'hC3);
        wait_idle();
        check(frames_seen == n0 + 2, "R7 cts ignored when gating off", frames_seen - n0, 2);
        check(last_gap() == frame_cyc(8, 0, 0), "R7 back to back with cts low",
              last_gap(), frame_cyc(8, 0, 0));

        // gating on, idle, cts low holds off
        auto_cts_en = 1; cts = 0;
        n0 = frames_seen;
        push_char(8'h81);
        repeat (300) @(negedge clk);
        check(txd == 1'b1 && busy == 1'b0, "R8 idle held while cts low", int'(busy), 0);
        check(txq.size() == 1, "R8 character stays queued", txq.size(), 1);
        check(tx_empty == 1'b0, "R12 tx_empty low with queued char", int'(tx_empty), 0);
        cts = 1;
        wait_idle();
        check(frames_seen == n0 + 1, "R8 starts once cts high", frames_seen - n0, 1);

        // cts drops before final stop midpoint: next blocked
        n0 = frames_seen;
        push_char(8'h96); push_char(8'h69);
        @(start_ev);
        repeat (400) @(negedge clk);
        cts = 0;
        repeat (400) @(negedge clk);
        check(busy == 1'b0 && txd == 1'b1, "R9 next blocked after early cts drop",
              int'(busy), 0);
        check(txq.size() == 1, "R9 second char still queued", txq.size(), 1);
        check(frames_seen == n0 + 1, "R11 first frame completed", frames_seen - n0, 1);
        cts = 1;
        wait_idle();
        check(frames_seen == n0 + 2, "R9 second sent after cts returns", frames_seen - n0, 2);

        // cts drops after final stop midpoint: next still starts
        push_char(8'hE7); push_char(8'h18);
        @(start_ev);
        repeat (620) @(negedge clk);
        cts = 0;
        wait_idle();
        check(last_gap() == frame_cyc(8, 0, 0), "R9 late cts drop keeps back to back",
              last_gap(), frame_cyc(8, 0, 0));
        cts = 1;

        // break
        mon_en = 0;
        brk = 1;
        repeat (3) @(negedge clk);
        check(txd == 1'b0, "R10 break forces low", int'(txd), 0);
        brk = 0;
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R10 line released", int'(txd), 1);
        mon_en = 1;

        check(exp_q.size() == 0, "R12 all queued chars emitted", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule